// File: doc/BRIEF.md
# Privileged Processor Flags Register

This block holds the 32-bit status and control flags word of a processor core and applies one flag command per clock. Commands force, clear or invert single flags, move the five arithmetic status flags to and from an 8-bit byte, read the word back as a 16-bit or 32-bit push image, and load it from a 16-bit or 32-bit pop image.

Pop loads are filtered by privilege. The two-bit I/O privilege field changes only when the caller runs at the most privileged level (0). The interrupt-enable flag changes only when the current I/O privilege field is numerically at least the caller's level. The wider pop can also change the alignment-check and identification bits.

The read word is combinational from the current state. Any update takes effect at the next rising clock edge. A separate output gives the step direction that string-index logic uses.

Top module: `flg_update_unit`

## Requirements
- R1: A synchronous reset (rst_n low at a rising edge) loads 0x00000002. At all times bit 1 of flags_o reads 1, and every bit outside {0,2,4,6,7,8,9,10,11,12,13,18,21} reads 0, even after a pop of all ones.
- R2: Command 1 sets carry (bit 0), command 2 clears it and command 3 inverts it. No other bit changes.
- R3: Command 4 sets the direction flag (bit 10) and command 5 clears it. step_o is 2'b01 (+1) when bit 10 is 0 and 2'b11 (-1) when it is 1.
- R4: Command 6 sets the interrupt-enable flag (bit 9) and command 7 clears it, regardless of privilege.
- R5: Command 8 places flag bits 7, 6, 4, 2 and 0 in rdata_o bits 7, 6, 4, 2 and 0, with rdata_o[31:8] zero. The flags word does not change.
- R6: Command 9 copies data_i bits 7, 6, 4, 2 and 0 into flag bits 7, 6, 4, 2 and 0. All other flag bits keep their value.
- R7: Command 10 returns {16'h0, flags[15:0]} on rdata_o and leaves the flags unchanged.
- R8: Command 11 returns the whole flags word with bits 17 and 16 forced to 0.
- R9: Command 12 (16-bit pop) copies data_i bits 11, 10, 8, 7, 6, 4, 2 and 0 into the flags. Bits 18 and 21 keep their value whatever data_i[31:16] holds.
- R10: For commands 12 and 13, flag bits 13:12 take data_i[13:12] only when cpl_i is 0. Otherwise they keep their value.
- R11: For commands 12 and 13, bit 9 takes data_i[9] only when the current flags[13:12] >= cpl_i. Otherwise it keeps its value.
- R12: Command 13 (32-bit pop) follows R9 to R11 and also copies data_i bits 18 and 21.
- R13: Codes 0, 14 and 15 change no flag, and rdata_o reads 0 for every code other than 8, 10 and 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_i | input | 4 | Flag command code |
| data_i | input | 32 | Byte-store or pop source word |
| cpl_i | input | 2 | Current privilege level of the caller |
| rdata_o | output | 32 | Byte-load or push read value |
| flags_o | output | 32 | Current flags word |
| step_o | output | 2 | Signed string step: +1 or -1 |

## Verification
The interrupt-enable guard is the hardest case to reach. It depends on the I/O privilege field, and that field can only be loaded by a privileged pop. The stimulus first pops a chosen field value at level 0. It then pops an image with the opposite interrupt bit at a level above the field, at a level equal to it, and at a level below it. Only the last two may change bit 9. A level-3 pop that tries to rewrite the field itself checks that the field holds its value.

// File: rtl/flg_pkg.sv
// Package: shared widths, bit positions, command codes and write masks
// for the flags register unit. Assumes a 32-bit flags word.
package flg_pkg;

    localparam int XLEN  = 32;
    localparam int CPL_W = 2;
    localparam int CMD_W = 4;

    localparam int B_CF = 0;
    localparam int B_DF = 10;
    localparam int B_IF = 9;
    localparam int B_IOPL_LO = 12;
    localparam int B_AC = 18;
    localparam int B_ID = 21;
    localparam int B_RF = 16;
    localparam int B_VM = 17;

    // bits that the five-flag byte transfer touches
    localparam logic [XLEN-1:0] BYTE_FLAGS   = 32'h0000_00D5;
    // pop bits written unconditionally
    localparam logic [XLEN-1:0] POP_BASE     = 32'h0000_0DD5;
    localparam logic [XLEN-1:0] POP_IOPL     = 32'h0000_3000;
    localparam logic [XLEN-1:0] POP_IF       = 32'h0000_0200;
    localparam logic [XLEN-1:0] POP_WIDE     = 32'h0024_0000;
    // all storage bits; everything else is constant
    localparam logic [XLEN-1:0] STORED_BITS  = POP_BASE | POP_IOPL | POP_IF | POP_WIDE;
    localparam logic [XLEN-1:0] FIXED_ONES   = 32'h0000_0002;
    localparam logic [XLEN-1:0] RESET_WORD   = FIXED_ONES;
    localparam logic [XLEN-1:0] PUSH_HIDE    = (32'h1 << B_RF) | (32'h1 << B_VM);

    typedef enum logic [CMD_W-1:0] {
        C_NOP       = 4'd0,
        C_CARRY_SET = 4'd1,
        C_CARRY_CLR = 4'd2,
        C_CARRY_INV = 4'd3,
        C_DIR_SET   = 4'd4,
        C_DIR_CLR   = 4'd5,
        C_INT_SET   = 4'd6,
        C_INT_CLR   = 4'd7,
        C_BYTE_LOAD = 4'd8,
        C_BYTE_STOR = 4'd9,
        C_PUSH_HALF = 4'd10,
        C_PUSH_FULL = 4'd11,
        C_POP_HALF  = 4'd12,
        C_POP_FULL  = 4'd13,
        C_RSV_E     = 4'd14,
        C_RSV_F     = 4'd15
    } flg_cmd_e;

endpackage

// File: rtl/flg_write_path.sv
// Module: turns one command into a write mask and a write value for the
// flags register. Assumes cur_i is the present register contents; the
// caller merges (cur & ~mask) | (value & mask).
module flg_write_path
    import flg_pkg::*;
(
    input  flg_cmd_e              cmd_i,
    input  logic [XLEN-1:0]       cur_i,
    input  logic [XLEN-1:0]       data_i,
    input  logic [CPL_W-1:0]      cpl_i,
    output logic [XLEN-1:0]       wmask_o,
    output logic [XLEN-1:0]       wval_o
);

    logic [CPL_W-1:0] iopl_cur;
    logic [XLEN-1:0]  pop_mask;
    logic [XLEN-1:0]  pop_src;

    assign iopl_cur = cur_i[B_IOPL_LO +: CPL_W];

    // privilege-filtered mask shared by both pop widths
    always_comb begin
        pop_mask = POP_BASE;
        if (cpl_i == '0)
            pop_mask = pop_mask | POP_IOPL;
        if (iopl_cur >= cpl_i)
            pop_mask = pop_mask | POP_IF;
        if (cmd_i == C_POP_FULL)
            pop_mask = pop_mask | POP_WIDE;
    end

    // half pop only sees the low word of the source
    assign pop_src = (cmd_i == C_POP_HALF) ? {{(XLEN-16){1'b0}}, data_i[15:0]} : data_i;

    // per-command selection of mask and value
    always_comb begin
        wmask_o = '0;
        wval_o  = '0;
        unique case (cmd_i)
            C_CARRY_SET: begin wmask_o[B_CF] = 1'b1; wval_o[B_CF] = 1'b1;          end
            C_CARRY_CLR: begin wmask_o[B_CF] = 1'b1; wval_o[B_CF] = 1'b0;          end
            C_CARRY_INV: begin wmask_o[B_CF] = 1'b1; wval_o[B_CF] = ~cur_i[B_CF];  end
            C_DIR_SET:   begin wmask_o[B_DF] = 1'b1; wval_o[B_DF] = 1'b1;          end
            C_DIR_CLR:   begin wmask_o[B_DF] = 1'b1; wval_o[B_DF] = 1'b0;          end
            C_INT_SET:   begin wmask_o[B_IF] = 1'b1; wval_o[B_IF] = 1'b1;          end
            C_INT_CLR:   begin wmask_o[B_IF] = 1'b1; wval_o[B_IF] = 1'b0;          end
            C_BYTE_STOR: begin wmask_o = BYTE_FLAGS; wval_o = {{(XLEN-8){1'b0}}, data_i[7:0]}; end
            C_POP_HALF,
            C_POP_FULL:  begin wmask_o = pop_mask;   wval_o = pop_src;             end
            default:     begin wmask_o = '0;         wval_o = '0;                  end
        endcase
    end

endmodule

// File: rtl/flg_read_mux.sv
// Module: combinational read port. Produces the byte image or a push
// image of the current flags; zero for non-reading commands.
module flg_read_mux
    import flg_pkg::*;
(
    input  flg_cmd_e              cmd_i,
    input  logic [XLEN-1:0]       cur_i,
    output logic [XLEN-1:0]       rdata_o
);

    // select the read image for the command
    always_comb begin
        unique case (cmd_i)
            C_BYTE_LOAD: rdata_o = {{(XLEN-8){1'b0}}, cur_i[7:0]};
            C_PUSH_HALF: rdata_o = {{(XLEN-16){1'b0}}, cur_i[15:0]};
            C_PUSH_FULL: rdata_o = cur_i & ~PUSH_HIDE;
            default:     rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/flg_update_unit.sv
// Module: top of the flags register unit. Holds the 32-bit flags word,
// applies one command per clock and exposes the read image, the flags and
// the string step direction. Assumes a synchronous active-low reset.
module flg_update_unit
    import flg_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [CMD_W-1:0]      cmd_i,
    input  logic [XLEN-1:0]       data_i,
    input  logic [CPL_W-1:0]      cpl_i,
    output logic [XLEN-1:0]       rdata_o,
    output logic [XLEN-1:0]       flags_o,
    output logic signed [1:0]     step_o
);

    flg_cmd_e        cmd;
    logic [XLEN-1:0] flags_q;
    logic [XLEN-1:0] wmask;
    logic [XLEN-1:0] wval;
    logic [XLEN-1:0] merged;

    assign cmd = flg_cmd_e'(cmd_i);

    flg_write_path u_wpath (
        .cmd_i   (cmd),
        .cur_i   (flags_q),
        .data_i  (data_i),
        .cpl_i   (cpl_i),
        .wmask_o (wmask),
        .wval_o  (wval)
    );

    flg_read_mux u_rmux (
        .cmd_i   (cmd),
        .cur_i   (flags_q),
        .rdata_o (rdata_o)
    );

    // merge masked write and pin constant bits
    assign merged = (((flags_q & ~wmask) | (wval & wmask)) & STORED_BITS) | FIXED_ONES;

    // flags register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= RESET_WORD;
        else        flags_q <= merged;
    end

    assign flags_o = flags_q;
    // string step from the direction flag
    assign step_o  = flags_q[B_DF] ? 2'sb11 : 2'sb01;

    AST_CONST_BITS:  assert property (@(posedge clk) disable iff (!rst_n)
        (flags_o & ~STORED_BITS) == FIXED_ONES);                                   // R1
    AST_CARRY_FLIP:  assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_CARRY_INV |=> flags_o[B_CF] != $past(flags_o[B_CF]));              // R2
    AST_BYTE_RO:     assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_BYTE_LOAD |=> flags_o == $past(flags_o));                          // R5
    AST_PUSH_HIDE:   assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_PUSH_FULL |-> rdata_o[B_VM:B_RF] == 2'b00);                        // R8
    AST_IOPL_GUARD:  assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == C_POP_HALF || cmd == C_POP_FULL) && cpl_i != '0)
        |=> flags_o[13:12] == $past(flags_o[13:12]));                               // R10
    AST_IF_GUARD:    assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd == C_POP_HALF || cmd == C_POP_FULL) && flags_o[13:12] < cpl_i)
        |=> flags_o[B_IF] == $past(flags_o[B_IF]));                                 // R11
    AST_HALF_HIGH:   assert property (@(posedge clk) disable iff (!rst_n)
        cmd == C_POP_HALF |=> flags_o[B_ID] == $past(flags_o[B_ID])
                              && flags_o[B_AC] == $past(flags_o[B_AC]));            // R9
    AST_STEP_SIGN:   assert property (@(posedge clk) disable iff (!rst_n)
        step_o == (flags_o[B_DF] ? -2'sd1 : 2'sd1));                                // R3

endmodule

// File: tb/test_flg_update_unit.sv
// Scoreboard bench: the driver applies commands and queues expected read
// and flag values from a bench model; a monitor pops and compares them.
module test_flg_update_unit;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  cmd_i = 4'd0;
    logic [31:0] data_i = '0;
    logic [1:0]  cpl_i = '0;
    logic [31:0] rdata_o;
    logic [31:0] flags_o;
    logic signed [1:0] step_o;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] mdl;

    typedef struct {
        logic [31:0] rd_exp;
        logic [31:0] rd_msk;
        logic [31:0] fl_exp;
        string       tag;
    } item_t;

    item_t sb_q[$];
    item_t pend;
    bit    pend_v = 0;
    bit    mon_on = 0;

    always #2.5 clk = ~clk;

    flg_update_unit i_flg_update_unit (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .data_i(data_i),
        .cpl_i(cpl_i), .rdata_o(rdata_o), .flags_o(flags_o), .step_o(step_o)
    );

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // bench model of one command's effect on the flags word
    function automatic logic [31:0] model_next(input logic [31:0] f, input logic [3:0] c,
                                               input logic [31:0] d, input logic [1:0] p);
        logic [31:0] n;
        n = f;
        case (c)
            4'd1: n[0] = 1'b1;
            4'd2: n[0] = 1'b0;
            4'd3: n[0] = ~f[0];
            4'd4: n[10] = 1'b1;
            4'd5: n[10] = 1'b0;
            4'd6: n[9] = 1'b1;
            4'd7: n[9] = 1'b0;
            4'd9: begin
                n[7] = d[7]; n[6] = d[6]; n[4] = d[4]; n[2] = d[2]; n[0] = d[0];
            end
            4'd12, 4'd13: begin
                n[0] = d[0]; n[2] = d[2]; n[4] = d[4]; n[6] = d[6]; n[7] = d[7];
                n[8] = d[8]; n[10] = d[10]; n[11] = d[11];
                if (p == 2'd0) n[13:12] = d[13:12];
                if (f[13:12] >= p) n[9] = d[9];
                if (c == 4'd13) begin n[18] = d[18]; n[21] = d[21]; end
            end
            default: ;
        endcase
        return n;
    endfunction

    // driver: drive one command and queue what it should produce
    task automatic apply(input logic [3:0] c, input logic [31:0] d, input logic [1:0] p,
                         input string tag);
        item_t it;
        @(negedge clk);
        cmd_i = c; data_i = d; cpl_i = p;
        it.rd_msk = 32'hFFFF_FFFF;
        case (c)
            4'd8:  begin it.rd_exp = {24'h0, mdl[7:0]}; it.rd_msk = 32'hFFFF_FFD5; end
            4'd10: it.rd_exp = {16'h0, mdl[15:0]};
            4'd11: it.rd_exp = {mdl[31:18], 2'b00, mdl[15:0]};
            default: it.rd_exp = 32'h0;
        endcase
        mdl = model_next(mdl, c, d, p);
        it.fl_exp = mdl;
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    // monitor: rdata of this cycle's command, flags of last cycle's command
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (mon_on) begin
                if (pend_v) begin
                    check(flags_o, pend.fl_exp, {pend.tag, " flags"});
                    check({30'h0, step_o}, {30'h0, pend.fl_exp[10] ? 2'b11 : 2'b01},
                          {pend.tag, " step R3"});
                    pend_v = 0;
                end
                if (sb_q.size() != 0) begin
                    pend = sb_q.pop_front();
                    pend_v = 1;
                    check(rdata_o & pend.rd_msk, pend.rd_exp & pend.rd_msk, {pend.tag, " rdata"});
                end
            end
        end
    end

    // watchdog
    initial begin
        #200000;
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check(flags_o, 32'h2, "R1 reset word");
        check({30'h0, step_o}, 32'h1, "R1 reset step");
        mdl = 32'h2;
        mon_on = 1;

        apply(4'd1, '0, 2'd3, "R2 carry set");
        apply(4'd3, '0, 2'd3, "R2 carry invert to 0");
        apply(4'd3, '0, 2'd3, "R2 carry invert to 1");
        apply(4'd2, '0, 2'd3, "R2 carry clear");
        apply(4'd4, '0, 2'd3, "R3 dir set");
        apply(4'd5, '0, 2'd3, "R3 dir clear");
        apply(4'd6, '0, 2'd3, "R4 int set");
        apply(4'd7, '0, 2'd3, "R4 int clear");
        apply(4'd9, 32'hFFFF_FF2A, 2'd3, "R6 byte store odd bits");
        apply(4'd9, 32'h0000_00FF, 2'd3, "R6 byte store ones");
        apply(4'd8, '0, 2'd3, "R5 byte load");
        apply(4'd13, 32'hFFFF_FFFF, 2'd0, "R1 R12 pop full all ones");
        apply(4'd11, '0, 2'd0, "R8 push full");
        apply(4'd10, '0, 2'd0, "R7 push half");
        apply(4'd8, '0, 2'd0, "R5 byte load after pop");
        apply(4'd12, 32'h0000_0000, 2'd0, "R9 pop half zeros keep high bits");
        apply(4'd13, 32'h0000_1000, 2'd0, "R12 R10 pop full iopl=1 clears 18 21");
        apply(4'd12, 32'hFFFF_FFFF, 2'd2, "R11 pop half if blocked cpl2 iopl1");
        apply(4'd12, 32'h0000_0200, 2'd1, "R11 pop half if allowed cpl1 iopl1");
        apply(4'd13, 32'h0000_3000, 2'd3, "R10 pop full iopl blocked cpl3");
        apply(4'd12, 32'h0000_0000, 2'd0, "R11 pop half cpl0 clears if");
        apply(4'd12, 32'h0024_0ED5, 2'd1, "R9 pop half ignores upper data");
        apply(4'd0, 32'hFFFF_FFFF, 2'd0, "R13 nop");
        apply(4'd14, 32'hFFFF_FFFF, 2'd0, "R13 code 14");
        apply(4'd15, 32'hFFFF_FFFF, 2'd0, "R13 code 15");
        apply(4'd4, '0, 2'd0, "R3 dir set again");
        apply(4'd11, '0, 2'd0, "R8 push full after dir");
        apply(4'd0, '0, 2'd0, "R13 flush");
        apply(4'd0, '0, 2'd0, "R13 flush");
        repeat (3) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule